// File: doc/BRIEF.md
# Transposed-Form FIR Filter with Zero-Tap Pruning

This block is a fully parallel FIR filter in transposed direct form. It takes one signed sample per clock when the input strobe is high and produces one filtered sample per accepted input. The coefficients are a constant parameter vector. At elaboration every tap whose coefficient is zero loses its multiplier. A tap whose mirror tap (index `NTAPS-1-k`) carries the same coefficient, or its negation, reuses that mirror's product instead of building a new multiplier.

Each new sample is broadcast to every tap multiplier. The products feed a chain of accumulator registers that advances one place toward the output only on cycles that carry a sample. Inside the chain the sum keeps full precision of `DW + CW + ceil(log2(NTAPS))` bits. The final cast drops `FRAC_DROP` low bits under one of six rounding rules and then narrows to `OW` bits by wrapping or by saturating. The pipeline has a fixed depth, so the latency does not depend on the tap count. A synchronous active-low reset clears all state.

Top module: `fir_transposed_pruned`

## Requirements
- R1: `flt_out_vld` equals `smp_in_vld` from exactly 6 clock edges earlier, for any tap count.
- R2: For each accepted sample x[n], the full-precision sum is S[n] = sum over k of c[k]*x[n-k]. Here c[k] is coefficient k, taken from bits `[k*CW +: CW]` of `COEFS`, and x[n-k] counts only accepted samples. The sum never overflows internally.
- R3: A tap with a zero coefficient has no multiplier, and its position contributes nothing to the output.
- R4: The cast computes q = floor(S / 2^FRAC_DROP) + b. With r = S - floor(S/2^FRAC_DROP)*2^FRAC_DROP and h = 2^(FRAC_DROP-1), the increment b depends on `ROUND`:
  - FLOOR (0): b = 0.
  - CEIL (1): b = (r != 0).
  - CONVERGENT (2): b = (r > h) or (r == h and floor is odd).
  - NEAREST (3), ties toward plus infinity: b = (r >= h).
  - HALF_AWAY (4): b = (r > h) or (r == h and S >= 0).
  - TRUNC_ZERO (5): b = (S < 0 and r != 0).
- R5: With `SATURATE` = 0, the output is the low `OW` bits of q, read as two's complement.
- R6: With `SATURATE` = 1, q is clamped to the range [-2^(OW-1), 2^(OW-1)-1].
- R7: A tap whose mirror has an equal coefficient takes the mirror's product. A tap whose mirror has the negated coefficient takes the negated product. The response stays that of the full coefficient set.
- R8: While `rst_n` is low at a clock edge, every register clears, including the tap history. The cycle after reset shows `flt_out_vld` = 0 and `flt_out` = 0, and a sample presented during reset is discarded.
- R9: On cycles with `smp_in_vld` low, `smp_in` is ignored and the tap history holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_in | input | DW | Signed input sample |
| smp_in_vld | input | 1 | Input sample strobe |
| flt_out | output | OW | Signed filtered, rounded and narrowed result |
| flt_out_vld | output | 1 | Output strobe |

## Verification
Two functions can act in the same cycle: the rounding step and the overflow step. When a rounding tie (remainder exactly half) occurs on a sum that already lies beyond the output range, the increment must be applied first and the clamp or wrap second. Directed constant inputs are chosen so that the steady-state sum is both a tie and out of range. Random full-scale samples also produce such sums. All twelve mode combinations are judged against an integer convolution model. A reset edge that coincides with a valid sample is also driven, and the sample must leave no trace.

// File: rtl/fir_pkg.sv
// Shared types for the transposed FIR filter.
package fir_pkg;
    // Rounding rule applied when low fraction bits are dropped at the output.
    typedef enum logic [2:0] {
        RND_FLOOR      = 3'd0,
        RND_CEIL       = 3'd1,
        RND_CONVERGENT = 3'd2,
        RND_NEAREST    = 3'd3,
        RND_HALF_AWAY  = 3'd4,
        RND_TRUNC_ZERO = 3'd5
    } round_e;
endpackage

// File: rtl/fir_tap_products.sv
// Per-tap product stage. Registers c[k]*x for every tap that needs its own
// multiplier. Zero taps produce a constant zero. A tap whose mirror holds an
// equal or negated coefficient reuses the mirror product.
// Assumes: x is held by the caller while x_vld is low.
module fir_tap_products #(
    parameter int DW = 8,
    parameter int CW = 8,
    parameter int NTAPS = 7,
    parameter logic [NTAPS*CW-1:0] COEFS = '0,
    parameter int PW = DW + CW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [DW-1:0] x,
    input  logic                 x_vld,
    output logic signed [PW-1:0] prod [NTAPS],
    output logic                 prod_vld
);
    logic signed [PW-1:0] own [NTAPS];

    for (genvar k = 0; k < NTAPS; k++) begin : g_tap
        localparam int M  = NTAPS - 1 - k;
        localparam int CK = $signed(COEFS[k*CW +: CW]);
        localparam int CM = $signed(COEFS[M*CW +: CW]);
        if (CK == 0) begin : g_zero
            assign own[k]  = '0;
            assign prod[k] = '0;
        end else if (k > M && CK == CM) begin : g_sym
            assign own[k]  = '0;
            assign prod[k] = own[M];
        end else if (k > M && CK == -CM) begin : g_anti
            assign own[k]  = '0;
            assign prod[k] = -own[M];
        end else begin : g_mult
            localparam logic signed [PW-1:0] CX = PW'(CK);
            logic signed [PW-1:0] p_q;
            // Multiply the broadcast sample by this tap's constant.
            always_ff @(posedge clk) begin
                if (!rst_n)     p_q <= '0;
                else if (x_vld) p_q <= PW'(x) * CX;
            end
            assign own[k]  = p_q;
            assign prod[k] = own[k];
        end
    end

    // Delay the strobe alongside the product registers.
    always_ff @(posedge clk) begin
        if (!rst_n) prod_vld <= 1'b0;
        else        prod_vld <= x_vld;
    end
endmodule

// File: rtl/fir_transposed_chain.sv
// Transposed accumulator chain. On each strobed cycle stage k takes its
// product plus the old contents of stage k+1, so stage 0 holds the full sum.
// Assumes: ACCW is wide enough for the worst case sum (no internal overflow).
module fir_transposed_chain #(
    parameter int NTAPS = 7,
    parameter int PW = 16,
    parameter int ACCW = 19
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic signed [PW-1:0]   prod [NTAPS],
    input  logic                   prod_vld,
    output logic signed [ACCW-1:0] sum,
    output logic                   sum_vld
);
    for (genvar k = 0; k < NTAPS; k++) begin : g_stage
        logic signed [ACCW-1:0] acc_q;
        if (k == NTAPS - 1) begin : g_tail
            // Last stage loads its own product only.
            always_ff @(posedge clk) begin
                if (!rst_n)        acc_q <= '0;
                else if (prod_vld) acc_q <= ACCW'(prod[k]);
            end
        end else begin : g_link
            // Add this tap's product to the partial sum from upstream.
            always_ff @(posedge clk) begin
                if (!rst_n)        acc_q <= '0;
                else if (prod_vld) acc_q <= g_stage[k+1].acc_q + ACCW'(prod[k]);
            end
        end
    end

    assign sum = g_stage[0].acc_q;

    // Strobe follows the chain update.
    always_ff @(posedge clk) begin
        if (!rst_n) sum_vld <= 1'b0;
        else        sum_vld <= prod_vld;
    end

    // Idle cycles must leave the chain untouched.
    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !prod_vld |=> $stable(sum));
endmodule

// File: rtl/fir_output_cast.sv
// Three-stage output cast: register the full sum, round away S low bits,
// then wrap or saturate to OW bits.
// Assumes: S >= 1 and S < ACCW.
module fir_output_cast #(
    parameter int ACCW = 19,
    parameter int S = 4,
    parameter int OW = 10,
    parameter fir_pkg::round_e ROUND = fir_pkg::RND_CONVERGENT,
    parameter bit SATURATE = 1'b1,
    parameter int QW = ACCW - S + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic signed [ACCW-1:0] sum,
    input  logic                   sum_vld,
    output logic signed [OW-1:0]   y,
    output logic                   y_vld
);
    localparam logic [S-1:0] HALF = S'(1) << (S - 1);

    logic signed [ACCW-1:0] sum_q;
    logic                   va, vb;
    logic signed [QW-1:0]   fl, q_q;
    logic [S-1:0]           rem;
    logic                   neg, bump;

    // Stage A: capture the full-precision sum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q <= '0;
            va    <= 1'b0;
        end else begin
            va <= sum_vld;
            if (sum_vld) sum_q <= sum;
        end
    end

    assign fl  = QW'(sum_q >>> S);
    assign rem = sum_q[S-1:0];
    assign neg = sum_q[ACCW-1];

    // Choose the rounding increment for the selected rule.
    always_comb begin
        unique case (ROUND)
            fir_pkg::RND_FLOOR:      bump = 1'b0;
            fir_pkg::RND_CEIL:       bump = |rem;
            fir_pkg::RND_CONVERGENT: bump = (rem > HALF) || (rem == HALF && fl[0]);
            fir_pkg::RND_NEAREST:    bump = (rem >= HALF);
            fir_pkg::RND_HALF_AWAY:  bump = (rem > HALF) || (rem == HALF && !neg);
            fir_pkg::RND_TRUNC_ZERO: bump = neg && (|rem);
            default:                 bump = 1'b0;
        endcase
    end

    // Stage B: apply the rounding increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_q <= '0;
            vb  <= 1'b0;
        end else begin
            vb <= va;
            if (va) q_q <= fl + QW'(bump);
        end
    end

    logic signed [OW-1:0] narrow;
    if (QW <= OW) begin : g_fits
        assign narrow = OW'(q_q);
    end else if (SATURATE) begin : g_sat
        localparam logic signed [QW-1:0] MAXV = {{(QW-OW+1){1'b0}}, {(OW-1){1'b1}}};
        localparam logic signed [QW-1:0] MINV = {{(QW-OW+1){1'b1}}, {(OW-1){1'b0}}};
        assign narrow = (q_q > MAXV) ? OW'(MAXV) :
                        (q_q < MINV) ? OW'(MINV) : OW'(q_q);
    end else begin : g_wrap
        assign narrow = OW'(q_q);
    end

    // Stage C: register the narrowed result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y     <= '0;
            y_vld <= 1'b0;
        end else begin
            y_vld <= vb;
            if (vb) y <= narrow;
        end
    end

    // Rounding moves the floor by at most one step.
    assert_round_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        va |=> (q_q == $past(fl) || q_q == $past(fl) + QW'(1)));
endmodule

// File: rtl/fir_transposed_pruned.sv
// Top of the transposed FIR: input register, tap products, accumulator
// chain and output cast, six registers deep from sample to result.
// Assumes: coefficient k sits at COEFS[k*CW +: CW]; S >= 1.
module fir_transposed_pruned #(
    parameter int DW = 8,
    parameter int CW = 8,
    parameter int NTAPS = 7,
    parameter logic [NTAPS*CW-1:0] COEFS =
        {8'sd12, 8'sd0, 8'sd40, 8'sd100, -8'sd40, 8'sd0, 8'sd12},
    parameter int FRAC_DROP = 4,
    parameter int OW = 10,
    parameter fir_pkg::round_e ROUND = fir_pkg::RND_CONVERGENT,
    parameter bit SATURATE = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [DW-1:0] smp_in,
    input  logic                 smp_in_vld,
    output logic signed [OW-1:0] flt_out,
    output logic                 flt_out_vld
);
    localparam int PW   = DW + CW;
    localparam int ACCW = DW + CW + $clog2(NTAPS);

    logic signed [DW-1:0]   x_q;
    logic                   x_vld;
    logic signed [PW-1:0]   prod [NTAPS];
    logic                   prod_vld;
    logic signed [ACCW-1:0] sum;
    logic                   sum_vld;

    // Input register: capture the sample on strobed cycles only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q   <= '0;
            x_vld <= 1'b0;
        end else begin
            x_vld <= smp_in_vld;
            if (smp_in_vld) x_q <= smp_in;
        end
    end

    fir_tap_products #(.DW(DW), .CW(CW), .NTAPS(NTAPS), .COEFS(COEFS), .PW(PW)) u_prod (
        .clk(clk), .rst_n(rst_n), .x(x_q), .x_vld(x_vld),
        .prod(prod), .prod_vld(prod_vld));

    fir_transposed_chain #(.NTAPS(NTAPS), .PW(PW), .ACCW(ACCW)) u_chain (
        .clk(clk), .rst_n(rst_n), .prod(prod), .prod_vld(prod_vld),
        .sum(sum), .sum_vld(sum_vld));

    fir_output_cast #(.ACCW(ACCW), .S(FRAC_DROP), .OW(OW), .ROUND(ROUND),
                      .SATURATE(SATURATE)) u_cast (
        .clk(clk), .rst_n(rst_n), .sum(sum), .sum_vld(sum_vld),
        .y(flt_out), .y_vld(flt_out_vld));

    // Count clean edges since reset, saturating, to gate the latency check.
    logic [2:0] rst_age;
    always_ff @(posedge clk) begin
        if (!rst_n)              rst_age <= '0;
        else if (rst_age != 3'd7) rst_age <= rst_age + 3'd1;
    end

    // Remember that the previous edge was a reset edge.
    logic rst_prev;
    always_ff @(posedge clk) rst_prev <= !rst_n;

    assert_valid_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_age >= 3'd6) |-> (flt_out_vld == $past(smp_in_vld, 6)));

    // After a reset edge the outputs are cleared.
    always_ff @(posedge clk) begin
        if (rst_prev) begin
            assert_reset_clear_R8: assert (!flt_out_vld && flt_out == '0);
        end
    end
endmodule

// File: tb/fir_transposed_pruned_test.sv
`timescale 1ns/1ps
module fir_transposed_pruned_test;
    localparam int DW = 8;
    localparam int NT = 7;
    localparam int SH = 4;
    localparam int OW = 10;
    localparam int NCFG = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic signed [DW-1:0] in_d = '0;
    logic in_vld = 1'b0;
    logic signed [OW-1:0] out_d [NCFG];
    logic out_v [NCFG];

    always #2 clk = ~clk;  // 250 MHz

    // One instance per rounding rule (0..5) and overflow rule (0 wrap, 1 saturate).
    for (genvar r = 0; r < 6; r++) begin : g_rnd
        for (genvar s = 0; s < 2; s++) begin : g_ovf
            fir_transposed_pruned #(
                .ROUND(fir_pkg::round_e'(r)), .SATURATE(s == 1)
            ) uut (
                .clk(clk), .rst_n(rst_n), .smp_in(in_d), .smp_in_vld(in_vld),
                .flt_out(out_d[r*2+s]), .flt_out_vld(out_v[r*2+s]));
        end
    end

    int coef [NT] = '{12, 0, -40, 100, 40, 0, 12};
    longint hist [NT];
    longint sumq [$];
    logic [5:0] vh = '0;
    int compared = 0;
    int mismatched = 0;
    bit checking = 1'b0;
    bit done = 1'b0;
    string tag = "R2";

    function automatic longint ref_cast(longint s, int mode, bit sat);
        longint fl = s >>> SH;
        longint r  = s - (fl <<< SH);
        longint h  = longint'(1) <<< (SH - 1);
        longint q  = fl;
        longint hi = (longint'(1) <<< (OW - 1)) - 1;
        longint lo = -(longint'(1) <<< (OW - 1));
        case (mode)
            1: if (r != 0) q++;
            2: if (r > h || (r == h && (fl & 1) != 0)) q++;
            3: if (r >= h) q++;
            4: if (r > h || (r == h && s >= 0)) q++;
            5: if (s < 0 && r != 0) q++;
            default: ;
        endcase
        if (sat) begin
            if (q > hi) q = hi;
            if (q < lo) q = lo;
        end else begin
            q = q & ((longint'(1) <<< OW) - 1);
            if (q > hi) q = q - (longint'(1) <<< OW);
        end
        return q;
    endfunction

    task automatic check_outputs();
        longint s;
        for (int c = 0; c < NCFG; c++) begin
            compared++;
            if (out_v[c] !== vh[5]) begin
                mismatched++;
                $display("FAIL R1 %s cfg=%0d valid got=%0b exp=%0b", tag, c, out_v[c], vh[5]);
            end
        end
        if (vh[5]) begin
            if (sumq.size() == 0) begin
                mismatched++;
                $display("FAIL R2 model queue empty got=1 exp=0");
            end else begin
                s = sumq.pop_front();
                for (int c = 0; c < NCFG; c++) begin
                    longint e = ref_cast(s, c / 2, bit'(c % 2));
                    compared++;
                    if (longint'(out_d[c]) != e) begin
                        mismatched++;
                        $display("FAIL %s R4 %s cfg=%0d sum=%0d got=%0d exp=%0d",
                                 tag, (c % 2) ? "R6" : "R5", c, s, out_d[c], e);
                    end
                end
            end
        end
    endtask

    task automatic cycle(bit rst, bit v, logic signed [DW-1:0] d);
        longint s = 0;
        @(negedge clk);
        if (checking) check_outputs();
        rst_n  = !rst;
        in_vld = v;
        in_d   = d;
        if (rst) begin
            foreach (hist[k]) hist[k] = 0;
            sumq.delete();
            vh = '0;
        end else begin
            vh = {vh[4:0], v};
            if (v) begin
                for (int k = NT - 1; k > 0; k--) hist[k] = hist[k-1];
                hist[0] = longint'(d);
                for (int k = 0; k < NT; k++) s += longint'(coef[k]) * hist[k];
                sumq.push_back(s);
            end
        end
    endtask

    task automatic check_cleared();
        @(negedge clk);
        for (int c = 0; c < NCFG; c++) begin
            compared++;
            if (out_v[c] !== 1'b0 || out_d[c] !== '0) begin
                mismatched++;
                $display("FAIL R8 cfg=%0d got=%0b/%0d exp=0/0", c, out_v[c], out_d[c]);
            end
        end
    endtask

    initial begin
        int seed_val;
        seed_val = $urandom(32'd2024);
        foreach (hist[k]) hist[k] = 0;
        repeat (4) cycle(1'b1, 1'b0, '0);
        checking = 1'b1;
        // R8: reset state
        tag = "R8";
        check_cleared();

        // R3 R7: impulse responses expose zero and mirrored taps; 2*12 gives a tie.
        tag = "R3 R7";
        cycle(1'b0, 1'b1, 8'sd2);
        repeat (9) cycle(1'b0, 1'b1, 8'sd0);
        cycle(1'b0, 1'b1, -8'sd128);
        repeat (9) cycle(1'b0, 1'b1, 8'sd0);

        // R4 R6: constant 70 gives steady sum 8680, a tie beyond output range.
        tag = "R4 R6 tie+overflow";
        repeat (12) cycle(1'b0, 1'b1, 8'sd70);
        repeat (12) cycle(1'b0, 1'b1, -8'sd70);
        // R2 R5: full-scale runs stress full precision and wrapping.
        tag = "R2 R5";
        repeat (12) cycle(1'b0, 1'b1, 8'sd127);
        repeat (12) cycle(1'b0, 1'b1, -8'sd128);

        // R9: idle cycles carry garbage data that must be ignored.
        tag = "R9";
        for (int i = 0; i < 120; i++) begin
            bit v = ($urandom_range(99) < 55);
            cycle(1'b0, v, DW'($urandom_range(255)));
        end

        // R2: dense random stream.
        tag = "R2 random";
        for (int i = 0; i < 400; i++) begin
            bit v = ($urandom_range(99) < 85);
            cycle(1'b0, v, DW'($urandom_range(255)));
        end

        // R8: reset with samples in flight, including one offered during reset.
        tag = "R8";
        cycle(1'b0, 1'b1, 8'sd99);
        cycle(1'b1, 1'b1, 8'sd55);
        check_cleared();
        tag = "R8 restart";
        cycle(1'b0, 1'b1, 8'sd3);
        repeat (10) cycle(1'b0, 1'b1, 8'sd0);

        // R1: drain so every result is seen.
        tag = "R1 drain";
        repeat (10) cycle(1'b0, 1'b0, 8'sd77);

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            mismatched++;
            $display("FAIL watchdog expired got=timeout exp=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule